// File: doc/BRIEF.md
# Streaming Data-Cache Line Fill Controller

This block serves a data-cache read miss to a cacheable address in slow shared memory. It fetches the whole line as a run of 32-bit words over a shared memory port, one request at a time, in ascending word order. Each word is written into the chosen set and way of the data array as it arrives. The stalled load is released as soon as the word it asked for has been written, while the remainder of the line keeps streaming in. After the last word arrives, the line's tag is installed together with its valid bit.

Two test-register bits change this behaviour. The first turns off streaming, so the load is held until the final word of the line has been written. The second turns off the line fill altogether: the miss then becomes one uncached word read, and nothing is allocated. Every request carries a sequential hint to the memory. The hint is clear for the first word of a fill, which costs a full random access of 9 memory cycles. It is set for later words, which cost 2 cycles, unless another master used the memory since this block's previous request. The block is busy from the moment a miss is accepted until the last word has been written, and it accepts no new miss while busy.

Top module: `dcf_stream_fill`

## Requirements
- R1: A miss presented on `miss_valid` while `busy` is low is accepted: `busy` is high in the next cycle, and the first word request goes out while it stays high.
- R2: With fill enabled, the block issues exactly one request per word, for word indices 0 up to LINE_WORDS-1 in ascending order. Each request address is the line base (address with bits [4:0] cleared) OR'ed with index*4. A request is held unchanged until `mem_req_ready`, and no new request is issued before the previous response has arrived.
- R3: Each response arriving during a fill is written to the data array in the same cycle. The write uses `cd_set`/`cd_way` from the miss, `cd_word` equal to the word index and `cd_wdata` equal to the response data. No write occurs outside a response cycle.
- R4: `ld_valid` pulses exactly once per fill, in the cycle the word with index miss address bits [4:2] is written.
- R5: With `cfg_nostream` set at the miss, the release moves to the cycle the last word (index 7) is written.
- R6: `ld_data` is taken from the returned word according to `miss_size`, and is zero-extended. Size 0 gives the byte at offset address[1:0], that is word >> (8*address[1:0]). Size 1 gives the halfword selected by address[1]. Size 2 gives the whole word.
- R7: With `cfg_nofill` set at the miss, exactly one request goes out, at the address with bits [1:0] cleared and with `mem_req_seq` clear. Its response raises `ld_valid` and writes neither the data array nor the tag.
- R8: `tag_we` is asserted together with the write of the last word. `tag_wdata` is {address[ADDR_W-1:5], set, 1'b1}, with the valid flag in bit 0.
- R9: `mem_req_seq` is 0 for word 0 and for uncached reads. For any later word it is 1, unless `mem_other_grant` was seen after the previous request of the fill was accepted.
- R10: `busy` falls in the cycle after the last word is written. A `miss_valid` raised while `busy` is high has no effect on the fill in progress.
- R11: After reset `busy`, `mem_req_valid`, `cd_we`, `tag_we` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss request |
| miss_addr | input | ADDR_W | Byte address of the missing load |
| miss_set | input | SET_W | Set chosen for the line |
| miss_way | input | WAY_W | Way chosen for the line |
| miss_size | input | 2 | Load size: 0 byte, 1 halfword, 2 word |
| cfg_nofill | input | 1 | Test bit: uncached single read, no allocation |
| cfg_nostream | input | 1 | Test bit: release the load only after the whole line |
| busy | output | 1 | A miss is in progress |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word-aligned request address |
| mem_req_seq | output | 1 | Sequential-access hint (fast timing) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| mem_other_grant | input | 1 | Another master was granted the memory |
| cd_we | output | 1 | Data-array word write |
| cd_set | output | SET_W | Data-array set |
| cd_way | output | WAY_W | Data-array way |
| cd_word | output | IDX_W | Word index inside the line |
| cd_wdata | output | DATA_W | Data-array write data |
| tag_we | output | 1 | Tag write |
| tag_set | output | SET_W | Tag set |
| tag_way | output | WAY_W | Tag way |
| tag_wdata | output | TAG_W | Tag entry {line address, set, valid} |
| ld_valid | output | 1 | Load release pulse |
| ld_data | output | DATA_W | Zero-extended load result |

## Verification
The bench aims the requested word at the first, a middle and the last slot of the line, because a wrong comparison index would release the load one word early or late, or never. The no-streaming and no-fill bits are applied alone and together: a design that ignored them would release at the requested word or allocate a line it must not touch. Foreign grants are injected during fills, and a controller that kept its sequential hint would claim fast timing after losing the memory. Misses raised while the block is busy check that the captured address is not overwritten during a fill, since a stray capture would redirect the remaining requests.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } dcf_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } dcf_state_e;

   localparam int WORD_BYTES = 4;
   localparam int WORD_LSB   = 2;
endpackage

// File: rtl/dcf_seq.sv
// Fill sequencer: walks word indices, owns the request/response handshake
// and remembers whether another master took the memory between words.
module dcf_seq #(
   parameter int LINE_WORDS = 8,
   localparam int IDX_W = $clog2(LINE_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             nofill,
   input  logic             req_ready,
   input  logic             rsp_valid,
   input  logic             other_grant,
   output logic             in_issue,
   output logic             in_wait,
   output logic [IDX_W-1:0] idx,
   output logic             last_word,
   output logic             seq_hint
);
   import dcf_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

   dcf_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             foreign_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         foreign_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q   <= ST_ISSUE;
                  idx_q     <= '0;
                  foreign_q <= 1'b0;
               end
            end
            ST_ISSUE: begin
               if (req_ready) begin
                  state_q   <= ST_WAIT;
                  foreign_q <= 1'b0;
               end else begin
                  foreign_q <= foreign_q | other_grant;
               end
            end
            ST_WAIT: begin
               foreign_q <= foreign_q | other_grant;
               if (rsp_valid) begin
                  if (nofill || idx_q == LAST_IDX) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_ISSUE;
                     idx_q   <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_issue  = (state_q == ST_ISSUE);
   assign in_wait   = (state_q == ST_WAIT);
   assign idx       = idx_q;
   assign last_word = (idx_q == LAST_IDX);
   assign seq_hint  = (idx_q != '0) && !foreign_q && !nofill;
endmodule

// File: rtl/dcf_addrgen.sv
// Request address and tag entry formation.
module dcf_addrgen #(
   parameter int ADDR_W     = 32,
   parameter int SET_W      = 5,
   parameter int LINE_WORDS = 8,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int LINE_LSB  = IDX_W + 2,
   localparam int TAG_W     = ADDR_W - LINE_LSB + SET_W + 1
) (
   input  logic [ADDR_W-1:2]  word_addr,
   input  logic [IDX_W-1:0]   idx,
   input  logic               nofill,
   input  logic [SET_W-1:0]   set,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [TAG_W-1:0]   tag_entry
);
   logic [ADDR_W-1:0] fill_addr;
   logic [ADDR_W-1:0] single_addr;

   assign fill_addr   = {word_addr[ADDR_W-1:LINE_LSB], idx, 2'b00};
   assign single_addr = {word_addr, 2'b00};
   assign req_addr    = nofill ? single_addr : fill_addr;
   assign tag_entry   = {word_addr[ADDR_W-1:LINE_LSB], set, 1'b1};
endmodule

// File: rtl/dcf_extract.sv
// Load result extraction: byte, halfword or word, zero-extended.
module dcf_extract #(
   parameter int DATA_W = 32,
   localparam int NB    = DATA_W / 8,
   localparam int NH    = DATA_W / 16,
   localparam int OFF_W = $clog2(NB)
) (
   input  logic [DATA_W-1:0] word,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] result
);
   import dcf_pkg::*;

   logic [7:0]  byte_lane [NB];
   logic [15:0] half_lane [NH];

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign byte_lane[b] = word[8*b +: 8];
   end
   for (genvar h = 0; h < NH; h++) begin : g_half
      assign half_lane[h] = word[16*h +: 16];
   end

   always_comb begin
      unique case (dcf_size_e'(size))
         SZ_BYTE: result = DATA_W'(byte_lane[off]);
         SZ_HALF: result = DATA_W'(half_lane[off[OFF_W-1:1]]);
         default: result = word;
      endcase
   end
endmodule

// File: rtl/dcf_stream_fill.sv
module dcf_stream_fill #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SET_W      = 5,
   parameter int WAY_W      = 2,
   parameter int LINE_WORDS = 8,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int LINE_LSB  = IDX_W + 2,
   localparam int TAG_W     = ADDR_W - LINE_LSB + SET_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic [SET_W-1:0]  miss_set,
   input  logic [WAY_W-1:0]  miss_way,
   input  logic [1:0]        miss_size,
   input  logic              cfg_nofill,
   input  logic              cfg_nostream,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic              mem_req_seq,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              mem_other_grant,
   output logic              cd_we,
   output logic [SET_W-1:0]  cd_set,
   output logic [WAY_W-1:0]  cd_way,
   output logic [IDX_W-1:0]  cd_word,
   output logic [DATA_W-1:0] cd_wdata,
   output logic              tag_we,
   output logic [SET_W-1:0]  tag_set,
   output logic [WAY_W-1:0]  tag_way,
   output logic [TAG_W-1:0]  tag_wdata,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dcf_stream_fill: DATA_W must be 32");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("dcf_stream_fill: LINE_WORDS must be a power of two >= 2");
   end
   if (ADDR_W <= LINE_LSB) begin : g_bad_addr_w
      $error("dcf_stream_fill: ADDR_W too small for the line size");
   end

   // captured miss
   logic [ADDR_W-1:0] addr_q;
   logic [SET_W-1:0]  set_q;
   logic [WAY_W-1:0]  way_q;
   logic [1:0]        size_q;
   logic              nofill_q;
   logic [IDX_W-1:0]  rel_q;

   logic              start;
   logic              in_issue, in_wait, last_word, seq_hint;
   logic [IDX_W-1:0]  idx;
   logic              rsp_take;

   assign start = miss_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         set_q    <= '0;
         way_q    <= '0;
         size_q   <= '0;
         nofill_q <= 1'b0;
         rel_q    <= '0;
      end else if (start) begin
         addr_q   <= miss_addr;
         set_q    <= miss_set;
         way_q    <= miss_way;
         size_q   <= miss_size;
         nofill_q <= cfg_nofill;
         rel_q    <= cfg_nostream ? IDX_W'(LINE_WORDS - 1) : miss_addr[LINE_LSB-1:2];
      end
   end

   dcf_seq #(.LINE_WORDS(LINE_WORDS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .nofill     (nofill_q),
      .req_ready  (mem_req_ready),
      .rsp_valid  (mem_rsp_valid),
      .other_grant(mem_other_grant),
      .in_issue   (in_issue),
      .in_wait    (in_wait),
      .idx        (idx),
      .last_word  (last_word),
      .seq_hint   (seq_hint)
   );

   dcf_addrgen #(
      .ADDR_W    (ADDR_W),
      .SET_W     (SET_W),
      .LINE_WORDS(LINE_WORDS)
   ) u_addr (
      .word_addr(addr_q[ADDR_W-1:2]),
      .idx      (idx),
      .nofill   (nofill_q),
      .set      (set_q),
      .req_addr (mem_req_addr),
      .tag_entry(tag_wdata)
   );

   dcf_extract #(.DATA_W(DATA_W)) u_ext (
      .word  (mem_rsp_data),
      .off   (addr_q[OFF_W-1:0]),
      .size  (size_q),
      .result(ld_data)
   );

   assign busy          = in_issue || in_wait;
   assign mem_req_valid = in_issue;
   assign mem_req_seq   = seq_hint;
   assign rsp_take      = in_wait && mem_rsp_valid;

   assign cd_we    = rsp_take && !nofill_q;
   assign cd_set   = set_q;
   assign cd_way   = way_q;
   assign cd_word  = idx;
   assign cd_wdata = mem_rsp_data;

   assign tag_we  = cd_we && last_word;
   assign tag_set = set_q;
   assign tag_way = way_q;

   assign ld_valid = rsp_take && (nofill_q || idx == rel_q);
endmodule

// File: rtl/dcf_stream_fill_chk.sv
module dcf_stream_fill_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int TAG_W      = 33,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int LINE_LSB  = IDX_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_req_seq,
   input logic              cd_we,
   input logic [IDX_W-1:0]  cd_word,
   input logic              tag_we,
   input logic [TAG_W-1:0]  tag_wdata,
   input logic              ld_valid
);
   logic released_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     released_q <= 1'b0;
      else if (!busy) released_q <= 1'b0;
      else if (ld_valid) released_q <= 1'b1;
   end

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R2
   req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid && !cd_we && !ld_valid);

   // R4
   single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> !released_q);

   // R8
   tag_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |-> cd_we && cd_word == IDX_W'(LINE_WORDS - 1) && tag_wdata[0]);

   // R9
   seq_not_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_seq |-> mem_req_addr[LINE_LSB-1:2] != '0);

   // R10
   done_after_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |=> !busy);
endmodule

bind dcf_stream_fill dcf_stream_fill_chk #(
   .ADDR_W    (ADDR_W),
   .LINE_WORDS(LINE_WORDS),
   .TAG_W     (TAG_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .mem_req_seq  (mem_req_seq),
   .cd_we        (cd_we),
   .cd_word      (cd_word),
   .tag_we       (tag_we),
   .tag_wdata    (tag_wdata),
   .ld_valid     (ld_valid)
);

// File: tb/dcf_stream_fill_test.sv
module dcf_stream_fill_test;
   localparam int ADDR_W = 32, DATA_W = 32, SET_W = 5, WAY_W = 2, LINE_WORDS = 8;
   localparam int IDX_W = 3, TAG_W = ADDR_W - 5 + SET_W + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic miss_valid = 1'b0;
   logic [ADDR_W-1:0] miss_addr = '0;
   logic [SET_W-1:0] miss_set = '0;
   logic [WAY_W-1:0] miss_way = '0;
   logic [1:0] miss_size = '0;
   logic cfg_nofill = 1'b0, cfg_nostream = 1'b0;
   logic busy, mem_req_valid, mem_req_seq;
   logic mem_req_ready = 1'b0;
   logic [ADDR_W-1:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data = '0;
   logic mem_other_grant = 1'b0;
   logic cd_we, tag_we, ld_valid;
   logic [SET_W-1:0] cd_set, tag_set;
   logic [WAY_W-1:0] cd_way, tag_way;
   logic [IDX_W-1:0] cd_word;
   logic [DATA_W-1:0] cd_wdata, ld_data;
   logic [TAG_W-1:0] tag_wdata;

   always #10 clk = ~clk;

   dcf_stream_fill uut (.*);

   int n_chk = 0, n_fail = 0;
   // expected state of the fill in progress
   logic [31:0] e_addr = '0;
   logic [SET_W-1:0] e_set = '0;
   logic [WAY_W-1:0] e_way = '0;
   logic [1:0] e_size = '0;
   logic e_nofill = 1'b0, e_nostream = 1'b0, e_fg = 1'b0;
   int e_idx = 0, e_rel = 0, n_req = 0;
   // memory model state
   logic pend = 1'b0, fgn_en = 1'b0;
   int cnt = 0;
   logic [31:0] paddr = '0;

   function automatic logic [31:0] memf(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] ext(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] off);
      if (sz == 2'd0) return (w >> (8 * off)) & 32'hFF;
      if (sz == 2'd1) return (w >> (16 * off[1])) & 32'hFFFF;
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: drives inputs shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         mem_rsp_valid = 1'b0;
         mem_other_grant = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data = memf(paddr);
               pend = 1'b0;
            end else begin
               cnt--;
               if (fgn_en && ($urandom % 3) == 0) mem_other_grant = 1'b1;
            end
         end
         mem_req_ready = ($urandom % 4) != 0;
      end
   end

   // monitor: samples mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_other_grant) e_fg = 1'b1;
         if (mem_req_valid && mem_req_ready) begin
            logic [31:0] ea;
            logic es;
            ea = e_nofill ? {e_addr[31:2], 2'b00} : {e_addr[31:5], 3'(e_idx), 2'b00};
            es = !e_nofill && e_idx != 0 && !e_fg;
            chk(mem_req_addr == ea, e_nofill ? "R7 address" : "R2 address", 64'(mem_req_addr), 64'(ea));
            chk(mem_req_seq == es, e_nofill ? "R7 seq" : "R9 seq", 64'(mem_req_seq), 64'(es));
            e_fg = 1'b0;
            n_req++;
            pend = 1'b1;
            cnt = mem_req_seq ? 1 : 8;
            paddr = mem_req_addr;
         end
         if (mem_rsp_valid) begin
            logic [31:0] w, el;
            w = mem_rsp_data;
            el = ext(w, e_size, e_addr[1:0]);
            if (e_nofill) begin
               chk(!cd_we && !tag_we, "R7 no write", {62'd0, cd_we, tag_we}, 64'd0);
               chk(ld_valid && ld_data == el, "R7/R6 load", {31'd0, ld_valid, ld_data}, {32'd1, el});
            end else begin
               chk(cd_we && cd_word == 3'(e_idx) && cd_wdata == w && cd_set == e_set && cd_way == e_way,
                   "R3 write", {cd_we, 20'd0, cd_set, cd_way, cd_word, cd_wdata},
                   {1'b1, 20'd0, e_set, e_way, 3'(e_idx), w});
               if (e_idx == e_rel)
                  chk(ld_valid && ld_data == el, e_nostream ? "R5 release" : "R4/R6 release",
                      {31'd0, ld_valid, ld_data}, {32'd1, el});
               else
                  chk(!ld_valid, e_nostream ? "R5 early" : "R4 early", 64'(ld_valid), 64'd0);
               if (e_idx == LINE_WORDS - 1) begin
                  logic [TAG_W-1:0] et;
                  et = {e_addr[31:5], e_set, 1'b1};
                  chk(tag_we && tag_wdata == et, "R8 tag", {30'd0, tag_we, tag_wdata}, {31'd1, et});
               end else begin
                  chk(!tag_we, "R8 early tag", 64'(tag_we), 64'd0);
               end
               e_idx++;
            end
         end else if (cd_we || ld_valid || tag_we) begin
            chk(1'b0, "R3 spurious", {61'd0, cd_we, ld_valid, tag_we}, 64'd0);
         end
      end
   end

   task automatic run_miss(input logic [31:0] a, input logic [1:0] sz, input bit nf, input bit ns,
                           input bit fg, input bit intrude);
      @(posedge clk);
      #2;
      miss_addr = a; miss_set = 5'($urandom); miss_way = 2'($urandom); miss_size = sz;
      cfg_nofill = nf; cfg_nostream = ns; miss_valid = 1'b1; fgn_en = fg;
      e_addr = a; e_set = miss_set; e_way = miss_way; e_size = sz; e_nofill = nf;
      e_nostream = ns; e_rel = ns ? 7 : int'(a[4:2]); e_idx = 0; e_fg = 1'b0; n_req = 0;
      @(posedge clk);
      #2;
      miss_valid = 1'b0;
      chk(busy, "R1 busy", 64'(busy), 64'd1);
      if (intrude) begin
         // R10: a second miss while busy must not be captured
         miss_addr = ~a; miss_set = ~e_set; miss_way = ~e_way; cfg_nofill = ~nf; cfg_nostream = ~ns;
         miss_size = 2'd2;
         miss_valid = 1'b1;
         repeat (4) @(posedge clk);
         #2;
         miss_valid = 1'b0;
      end
      while (busy) begin
         @(posedge clk);
         #2;
      end
      chk(n_req == (nf ? 1 : LINE_WORDS), "R10 request count", 64'(n_req), 64'(nf ? 1 : LINE_WORDS));
      chk(e_nofill || e_idx == LINE_WORDS, "R10 busy fell early", 64'(e_idx), 64'(LINE_WORDS));
      fgn_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      #2;
      // R11 reset state
      chk(!busy && !mem_req_valid && !cd_we && !tag_we && !ld_valid, "R11 reset",
          {59'd0, busy, mem_req_valid, cd_we, tag_we, ld_valid}, 64'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk(!busy, "R11 idle after reset", 64'(busy), 64'd0);
      // directed corners
      run_miss(32'h0200_1000, 2'd2, 0, 0, 0, 0);   // release at word 0
      run_miss(32'h0200_105C, 2'd2, 0, 0, 0, 0);   // release at word 7
      run_miss(32'h0200_234D, 2'd0, 0, 0, 0, 0);   // byte, middle word
      run_miss(32'h0200_3046, 2'd1, 0, 0, 0, 0);   // upper halfword
      run_miss(32'h0200_4004, 2'd2, 0, 1, 0, 0);   // R5 forced to last word
      run_miss(32'h0200_5013, 2'd0, 1, 0, 0, 0);   // R7 uncached byte
      run_miss(32'h0200_6018, 2'd2, 1, 1, 0, 0);   // R7 with both bits
      run_miss(32'h0200_7008, 2'd2, 0, 0, 1, 0);   // R9 foreign grants
      run_miss(32'h0200_8010, 2'd1, 0, 0, 0, 1);   // R10 miss while busy
      for (int i = 0; i < 40; i++) begin
         logic [31:0] a;
         a = $urandom;
         run_miss(a, 2'($urandom % 3), ($urandom % 6) == 0, ($urandom % 5) == 0,
                  ($urandom % 2) == 1, ($urandom % 4) == 0);
      end
      repeat (3) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule